// File: doc/BRIEF.md
# Flash Operation Status Flag Unit

This block stands in for the status logic of a small embedded flash array. The array runs its program and chip-erase operations by itself. The host starts an operation with a single command on `cmd_op`. A program command carries an address and a data byte. A chip-erase command needs neither. The host may read at any moment. While an operation is in progress, a read returns a status byte instead of array contents. That byte carries a data-polling bit, a bit that alternates on every read and a time-out bit. Once the operation has finished, reads return the stored bytes again.

Programming can only clear bits. A program request that would need to raise a stored 0 to 1 can never finish. The block then stays busy and its elapsed-time counter runs past the allowed limit, so the time-out bit turns to 1. The block stays in that failed state until the host issues a reset command. Chip erase behaves the same way with respect to time-out, using its own duration and limit.

Top module: `flash_status_unit`

## Requirements
- R1: After `rst_n` is released, every cell of the array reads 0xFF and the block is in read mode, so a read returns the stored byte.
- R2: A program command (`cmd_op` = 1) accepted in read mode keeps the block busy for exactly PROG_CYC clock cycles after the accepting edge. After that, a read of the target address returns the programmed result.
- R3: While busy, `rd_data` is a status byte. Bit 7 is the data-polling bit: the inverse of bit 7 of the data being programmed, or 0 during chip erase. Bit 6 is the toggle bit. Bit 5 is the time-out bit. Bits 4 to 0 are 0.
- R4: The toggle bit is 0 when an operation starts. It inverts at each clock edge where `rd_en` is high while busy, and it does not change on cycles without `rd_en`.
- R5: During an operation, the time-out bit reads 0 for fewer than LIMIT elapsed cycles since the accepting edge. From cycle LIMIT onward it reads 1. LIMIT is PROG_LIMIT for programming and ERASE_LIMIT for erasing.
- R6: A program request whose data sets a bit that the stored byte has cleared, that is (stored AND data) differs from data, never completes. The block stays busy and the array is left unchanged.
- R7: A reset command (`cmd_op` = 3) is accepted in every state. It returns the block to read mode at the next edge, clears the elapsed-time counter and the toggle bit, and leaves the array contents as they are. A reset during an erase therefore aborts that erase.
- R8: A chip-erase command (`cmd_op` = 2) accepted in read mode keeps the block busy for ERASE_CYC cycles and then sets every cell to 0xFF.
- R9: Program and chip-erase commands that arrive while the block is busy are ignored and have no effect on the running operation or on the array.
- R10: A program whose data keeps only bits already set stores exactly that data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_op | input | 2 | Command: 0 none, 1 program, 2 chip erase, 3 reset |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_data | input | 8 | Program data byte |
| rd_en | input | 1 | Read strobe; advances the toggle bit while busy |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte in read mode, status byte while busy |

## Verification
The bench builds the block with ADDR_W = 3, PROG_CYC = 4, ERASE_CYC = 6, PROG_LIMIT = 10 and ERASE_LIMIT = 12. With these values all eight cells can be visited one by one, and every busy cycle of a program or erase operation can be read one after another. A stuck program crosses its time-out threshold within a dozen reads, so the bench can compare the exact cycle where the time-out bit turns to 1 with a value it computes from the parameters. Stored values come from a small address formula that the bench evaluates itself, and the bench forms the status bytes from bit arithmetic of its own.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } fsu_op_e;

  typedef enum logic [1:0] {
    PH_READ  = 2'd0,
    PH_PROG  = 2'd1,
    PH_ERASE = 2'd2
  } fsu_phase_e;

  // Programming may only clear bits: every 1 in the request must already be stored.
  function automatic logic prog_allowed(input logic [7:0] stored, input logic [7:0] data);
    return (stored & data) == data;
  endfunction

  function automatic logic [7:0] status_byte(input logic poll, input logic tog, input logic tmo);
    return {poll, tog, tmo, 5'b00000};
  endfunction

endpackage

// File: rtl/fsu_cell_array.sv
module fsu_cell_array #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fill,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [WORD_W-1:0] tgt_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= '1;
      else if (fill)
        cells[g] <= '1;
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        cells[g] <= wr_data;
    end
  end

  assign rd_word  = cells[rd_addr];
  assign tgt_word = cells[tgt_addr];
endmodule

// File: rtl/fsu_op_timer.sv
module fsu_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] elapsed,
  output logic             expired
);
  // Saturates at the limit so a stuck operation never wraps back below it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed <= '0;
    else if (clear)
      elapsed <= '0;
    else if (run && (elapsed < limit))
      elapsed <= elapsed + 1'b1;
  end

  assign expired = (elapsed >= limit);
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsu_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PROG_CYC    = 64,
  parameter int ERASE_CYC   = 2000,
  parameter int PROG_LIMIT  = 256,
  parameter int ERASE_LIMIT = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int MAX_LIM = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] PROG_END  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_END = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LIM  = CNT_W'(PROG_LIMIT);
  localparam logic [CNT_W-1:0] ERASE_LIM = CNT_W'(ERASE_LIMIT);

  fsu_phase_e        phase;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        tgt_data;
  logic              toggle;

  // Named internal events, observed by the bound checker.
  logic              busy, prog_phase, cmd_rst, start_prog, start_erase, op_start;
  logic              prog_ok, reach_end, op_finish, timed_out;
  logic [CNT_W-1:0]  elapsed, cur_limit, cur_end;
  logic [7:0]        rd_word, tgt_word;

  assign busy        = (phase != PH_READ);
  assign prog_phase  = (phase == PH_PROG);
  assign cmd_rst     = (cmd_op == OP_RESET);
  assign start_prog  = !busy && (cmd_op == OP_PROG);
  assign start_erase = !busy && (cmd_op == OP_ERASE);
  assign op_start    = start_prog || start_erase;
  assign cur_limit   = prog_phase ? PROG_LIM : ERASE_LIM;
  assign cur_end     = prog_phase ? PROG_END : ERASE_END;
  assign prog_ok     = prog_allowed(tgt_word, tgt_data);
  assign reach_end   = busy && (elapsed == cur_end);
  assign op_finish   = reach_end && !cmd_rst && (!prog_phase || prog_ok);

  fsu_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cmd_rst || op_start),
    .run     (busy),
    .limit   (cur_limit),
    .elapsed (elapsed),
    .expired (timed_out)
  );

  fsu_cell_array #(.ADDR_W(ADDR_W), .WORD_W(8)) u_cells (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (op_finish && prog_phase),
    .wr_addr  (tgt_addr),
    .wr_data  (tgt_data),
    .fill     (op_finish && (phase == PH_ERASE)),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word),
    .tgt_addr (tgt_addr),
    .tgt_word (tgt_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_READ;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else if (cmd_rst || op_finish) begin
      phase <= PH_READ;
    end else if (start_prog) begin
      phase    <= PH_PROG;
      tgt_addr <= cmd_addr;
      tgt_data <= cmd_data;
    end else if (start_erase) begin
      phase <= PH_ERASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      toggle <= 1'b0;
    else if (cmd_rst || op_start)
      toggle <= 1'b0;
    else if (busy && rd_en)
      toggle <= ~toggle;
  end

  assign rd_data = busy ? status_byte(prog_phase & ~tgt_data[7], toggle, timed_out) : rd_word;
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_op,
  input logic       rd_en,
  input logic       busy,
  input logic       prog_phase,
  input logic       prog_ok,
  input logic       op_finish,
  input logic       timed_out,
  input logic       toggle
);
  p_reset_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd3) |=> !busy);

  p_timeout_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> !timed_out);

  p_timeout_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && timed_out && cmd_op != 2'd3) |=> timed_out);

  p_finish_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_finish && prog_phase) |-> prog_ok);

  p_kind_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_op != 2'd3 && !op_finish) |=> (busy && $stable(prog_phase)));

  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && cmd_op != 2'd3) |=> (toggle != $past(toggle)));

  p_toggle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_en && cmd_op != 2'd3) |=> (toggle == $past(toggle)));
endmodule

bind flash_status_unit fsu_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_op     (cmd_op),
  .rd_en      (rd_en),
  .busy       (busy),
  .prog_phase (prog_phase),
  .prog_ok    (prog_ok),
  .op_finish  (op_finish),
  .timed_out  (timed_out),
  .toggle     (toggle)
);

// File: tb/sim_flash_status_unit.sv
`timescale 1ns/1ps
module sim_flash_status_unit;
  localparam int AW = 3, PC = 4, EC = 6, PL = 10, EL = 12;
  localparam int NC = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = 8'h00;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] model [NC];
  logic tog;

  always #10 clk = ~clk;

  flash_status_unit #(.ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC),
                      .PROG_LIMIT(PL), .ERASE_LIMIT(EL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [7:0] stat(input logic poll, input logic t, input logic tmo);
    return (8'(poll) << 7) | (8'(t) << 6) | (8'(tmo) << 5);
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  // One cycle: read, compare, advance; bench toggle follows R4.
  task automatic peek(input logic [AW-1:0] a, input logic en, input logic [7:0] exp,
                      input string req);
    rd_addr = a; rd_en = en;
    #1 check(rd_data, exp, req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < NC; a++) peek(AW'(a), 1'b1, model[a], req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < NC; a++) model[a] = 8'hFF;
    check_all("R1");

    // R2 R3 R4 R10: program every cell, reading each busy cycle
    for (int a = 0; a < NC; a++) begin
      logic [7:0] d;
      d = 8'((a * 37) ^ 8'h5A);
      send(2'd1, AW'(a), d);
      tog = 1'b0;
      for (int i = 0; i < PC; i++) begin
        logic en;
        en = (i != 1);
        peek(AW'(a), en, stat(~d[7], tog, 1'b0), "R3 R4 busy status");
        if (en) tog = ~tog;
      end
      model[a] = d;
      peek(AW'(a), 1'b1, d, "R2 R10 readback");
    end

    // R10: clear further bits of cell 0
    send(2'd1, '0, model[0] & 8'h0F);
    repeat (PC) @(negedge clk);
    model[0] = model[0] & 8'h0F;
    peek('0, 1'b1, model[0], "R10 second program");

    // R9: erase and another program while a program is running
    send(2'd1, AW'(1), model[1] & 8'hF0);
    send(2'd2, '0, 8'h00);
    send(2'd1, AW'(5), 8'h00);
    tog = 1'b0;
    for (int i = 2; i < PC; i++) begin
      peek(AW'(1), 1'b1, stat(~model[1][7], tog, 1'b0), "R9 busy status");
      tog = ~tog;
    end
    model[1] = model[1] & 8'hF0;
    check_all("R9 array after ignored commands");

    // R5 R6: impossible program on cell 2 hits time-out
    send(2'd1, AW'(2), 8'hFF);
    tog = 1'b0;
    for (int i = 0; i < PL + 5; i++) begin
      peek(AW'(2), 1'b1, stat(1'b0, tog, (i >= PL)), "R5 R6 stuck status");
      tog = ~tog;
    end
    repeat (20) @(negedge clk);
    peek(AW'(2), 1'b1, stat(1'b0, tog, 1'b1), "R6 still stuck");
    send(2'd3, '0, 8'h00);
    check_all("R7 R6 array after reset");

    // R7: reset during erase aborts it
    send(2'd2, '0, 8'h00);
    peek('0, 1'b1, stat(1'b0, 1'b0, 1'b0), "R8 erase status");
    peek('0, 1'b1, stat(1'b0, 1'b1, 1'b0), "R8 erase status");
    send(2'd3, '0, 8'h00);
    check_all("R7 aborted erase");

    // R8: full erase
    send(2'd2, '0, 8'h00);
    tog = 1'b0;
    for (int i = 0; i < EC; i++) begin
      peek(AW'(i % NC), 1'b1, stat(1'b0, tog, 1'b0), "R8 erase status");
      tog = ~tog;
    end
    for (int a = 0; a < NC; a++) model[a] = 8'hFF;
    check_all("R8 erased");

    // R7 R5: timers cleared; a fresh program finishes with time-out bit 0
    send(2'd1, AW'(6), 8'h80);
    tog = 1'b0;
    for (int i = 0; i < PC; i++) begin
      peek(AW'(6), 1'b1, stat(1'b0, tog, 1'b0), "R7 R5 fresh program");
      tog = ~tog;
    end
    peek(AW'(6), 1'b1, 8'h80, "R2 readback after erase");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule